// File: doc/BRIEF.md
# Prioritized Interrupt Claim Arbiter

The block keeps one pending bit per numbered interrupt source and, for each of several interrupt targets, picks the most urgent source that the target may see. Every source carries a programmable priority. Every target has its own enable mask and its own priority threshold. A target's interrupt line is raised when at least one of its enabled, pending sources has a priority above that threshold.

Gateways upstream raise pending bits through a set vector. A target takes work by pulsing its claim request. In that cycle the block returns the ID of the selected source, and at the next clock edge it clears that source's pending bit. An ID of zero means there was nothing to take.

Configuration goes through a plain register write port with a combinational read-back. Sources are numbered from 1, so ID 0 stays free for "nothing". There is no data stream, so every pin is plain control and status and no valid/ready handshake is used.

Top module: `irq_claim_arbiter`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears all pending bits, priorities, enable masks and thresholds. While reset is held and just after it, `eip` is 0 and every `claim_id` field reads 0.
- R2: A write uses `reg_addr[5:4]` as the kind and `reg_addr[3:0]` as the index. Kind 0 writes the priority of source ID = index, and only IDs 1..8 are stored. Kind 1 writes the enable mask of target = index, where data bit k enables source k+1. Kind 2 writes the threshold of target = index. `reg_rdata` returns the stored value at `reg_addr`, and 0 for unused indices.
- R3: `gw_set` bit k sets the pending bit of source k+1 at the clock edge, and that bit stays set until it is claimed.
- R4: `eip[t]` is 1 exactly when some pending source enabled for target t has a priority strictly greater than target t's threshold.
- R5: A source with priority 0 never raises `eip` and is never returned by a claim.
- R6: Among the eligible sources, the one with the highest priority is selected. On equal priority, the lowest ID wins.
- R7: While `claim_req[t]` is high, `claim_id[4t+3:4t]` carries the selected ID. That source's pending bit is cleared at the clock edge.
- R8: A claim with no eligible source returns 0 and changes nothing. Without `claim_req[t]`, field t reads 0.
- R9: If two targets claim the same source in one cycle, the lower-numbered target gets the ID and the other gets 0.
- R10: A `gw_set` bit arriving in the same cycle as a claim of that source is dropped, so the bit ends up cleared. A set held into the next cycle pends the source again.
- R11: Thresholds and enable masks act per target. Raising one target's threshold to a source's priority masks that source for that target only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register kind [5:4] and index [3:0] |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| gw_set | input | 8 | Set-pending from gateways, bit k = source k+1 |
| claim_req | input | 2 | Claim request per target |
| claim_id | output | 8 | Claimed ID, 4 bits per target |
| eip | output | 2 | External interrupt pending per target |

## Verification
A claim that clears a source's pending bit and a gateway set of that same source can arrive in the same cycle. The bench provokes this by holding `gw_set` for the source during the cycle in which target 0 claims it. It then checks that both targets' interrupt lines drop on the following cycle, and that they return one cycle later once the held set is accepted. Two targets claiming the one shared eligible source in the same cycle are also driven together, and the bench checks that exactly one non-zero ID comes back.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    KIND_PRIO   = 2'd0,
    KIND_ENABLE = 2'd1,
    KIND_THRESH = 2'd2,
    KIND_RSVD   = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_arb_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int N_TGT  = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [PRIO_W-1:0] prio_o [N_SRC],
  output logic [N_SRC-1:0]  en_o   [N_TGT],
  output logic [PRIO_W-1:0] thr_o  [N_TGT]
);
  localparam int SEL_W = ADDR_W - 2;

  reg_kind_e        kind;
  logic [SEL_W-1:0] idx;
  assign kind = reg_kind_e'(addr_i[ADDR_W-1 -: 2]);
  assign idx  = addr_i[SEL_W-1:0];

  for (genvar s = 0; s < N_SRC; s++) begin : g_prio
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prio_o[s] <= '0;
      else if (wr_en_i && kind == KIND_PRIO && idx == SEL_W'(s + 1))
        prio_o[s] <= wdata_i[PRIO_W-1:0];
    end
  end

  for (genvar t = 0; t < N_TGT; t++) begin : g_tgt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_o[t]  <= '0;
        thr_o[t] <= '0;
      end else if (wr_en_i && idx == SEL_W'(t)) begin
        if (kind == KIND_ENABLE) en_o[t]  <= wdata_i[N_SRC-1:0];
        if (kind == KIND_THRESH) thr_o[t] <= wdata_i[PRIO_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int s = 0; s < N_SRC; s++)
      if (kind == KIND_PRIO && idx == SEL_W'(s + 1)) rdata_o = DATA_W'(prio_o[s]);
    for (int t = 0; t < N_TGT; t++) begin
      if (kind == KIND_ENABLE && idx == SEL_W'(t)) rdata_o = DATA_W'(en_o[t]);
      if (kind == KIND_THRESH && idx == SEL_W'(t)) rdata_o = DATA_W'(thr_o[t]);
    end
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  // A claim clear outranks a set arriving in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= (pend_o | set_i) & ~clr_i;
  end

  // R3: a pending bit not cleared stays set
  a_r3_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_o & ~$past(clr_i)) & $past(pend_o)) == ($past(pend_o) & ~$past(clr_i)));
endmodule

// File: rtl/irq_target_sel.sv
module irq_target_sel #(
  parameter int N_SRC  = 8,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 4
) (
  input  logic [N_SRC-1:0]  pend_i,
  input  logic [N_SRC-1:0]  en_i,
  input  logic [PRIO_W-1:0] prio_i [N_SRC],
  input  logic [PRIO_W-1:0] thr_i,
  output logic [ID_W-1:0]   id_o,
  output logic              eip_o
);
  logic [PRIO_W-1:0] best_p;

  // Strict compare: a later (higher) ID only wins with a higher priority,
  // and starting at the threshold makes priority 0 never eligible.
  always_comb begin
    best_p = thr_i;
    id_o   = '0;
    for (int k = 0; k < N_SRC; k++) begin
      if (pend_i[k] && en_i[k] && prio_i[k] > best_p) begin
        best_p = prio_i[k];
        id_o   = ID_W'(k + 1);
      end
    end
  end

  assign eip_o = (id_o != '0);

  // R4 / R5: interrupt line only with an enabled pending source of nonzero priority
  always_comb begin
    a_r4_eip_has_source: assert (!eip_o || (pend_i & en_i) != '0);
    a_r5_id_in_range: assert (int'(id_o) <= N_SRC);
  end
endmodule

// File: rtl/irq_claim_arbiter.sv
module irq_claim_arbiter #(
  parameter int N_SRC  = 8,
  parameter int N_TGT  = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr_en,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [N_SRC-1:0]        reg_wdata,
  output logic [N_SRC-1:0]        reg_rdata,
  input  logic [N_SRC-1:0]        gw_set,
  input  logic [N_TGT-1:0]        claim_req,
  output logic [N_TGT*$clog2(N_SRC+1)-1:0] claim_id,
  output logic [N_TGT-1:0]        eip
);
  localparam int ID_W   = $clog2(N_SRC + 1);
  localparam int DATA_W = N_SRC;

  logic [PRIO_W-1:0] prio   [N_SRC];
  logic [N_SRC-1:0]  en     [N_TGT];
  logic [PRIO_W-1:0] thr    [N_TGT];
  logic [ID_W-1:0]   sel_id [N_TGT];
  logic [N_SRC-1:0]  pend;
  logic [N_SRC-1:0]  clr;
  logic [N_TGT-1:0]  grant;

  irq_cfg_regs #(
    .N_SRC(N_SRC), .N_TGT(N_TGT), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en_i(reg_wr_en), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .prio_o(prio), .en_o(en), .thr_o(thr)
  );

  irq_pend_bank #(.N_SRC(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(gw_set), .clr_i(clr), .pend_o(pend)
  );

  for (genvar t = 0; t < N_TGT; t++) begin : g_sel
    irq_target_sel #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_sel (
      .pend_i(pend), .en_i(en[t]), .prio_i(prio), .thr_i(thr[t]),
      .id_o(sel_id[t]), .eip_o(eip[t])
    );
  end

  // Claim resolution: lower-numbered target wins a shared source.
  always_comb begin
    clr = '0;
    for (int t = 0; t < N_TGT; t++) begin
      grant[t] = claim_req[t] && sel_id[t] != '0;
      for (int u = 0; u < t; u++)
        if (claim_req[u] && sel_id[u] == sel_id[t]) grant[t] = 1'b0;
      claim_id[t*ID_W +: ID_W] = grant[t] ? sel_id[t] : '0;
      for (int k = 0; k < N_SRC; k++)
        if (grant[t] && sel_id[t] == ID_W'(k + 1)) clr[k] = 1'b1;
    end
  end

  // R7: a granted source is no longer pending on the next cycle
  a_r7_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> (pend & $past(clr)) == '0);

  // R10: a set coinciding with a claim of the same source is dropped
  a_r10_set_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    ((gw_set & clr) != '0) |=> (pend & $past(gw_set & clr)) == '0);

  for (genvar t = 0; t < N_TGT; t++) begin : g_chk
    // R8: no request, no ID
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !claim_req[t] |-> claim_id[t*ID_W +: ID_W] == '0);
    // R7: a returned ID was pending before the edge
    a_r7_id_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
      claim_id[t*ID_W +: ID_W] != '0 |-> pend[claim_id[t*ID_W +: ID_W] - 1'b1]);
    for (genvar u = t + 1; u < N_TGT; u++) begin : g_pair
      // R9: one source never handed to two targets at once
      a_r9_no_double_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_id[t*ID_W +: ID_W] != '0 && claim_id[u*ID_W +: ID_W] != '0)
          |-> claim_id[t*ID_W +: ID_W] != claim_id[u*ID_W +: ID_W]);
    end
  end
endmodule

// File: tb/irq_claim_arbiter_tb_top.sv
module irq_claim_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr_en;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [7:0] gw_set;
  logic [1:0] claim_req;
  logic [7:0] claim_id;
  logic [1:0] eip;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  irq_claim_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gw_set(gw_set),
    .claim_req(claim_req), .claim_id(claim_id), .eip(eip)
  );

  // {wr, addr, wdata, set, creq, exp_eip, exp_c1, exp_c0, req_tag}
  // Enables: target0 = sources 1-4, target1 = sources 1 and 4.
  localparam int VW = 39;
  localparam logic [VW-1:0] VEC [0:24] = '{
    {1'b1, 6'h01, 8'd3,   8'h00, 2'b00, 2'b00, 4'd0, 4'd0, 4'd2},  // R2 prio src1=3
    {1'b1, 6'h02, 8'd5,   8'h00, 2'b00, 2'b00, 4'd0, 4'd0, 4'd2},  // R2 prio src2=5
    {1'b1, 6'h03, 8'd5,   8'h00, 2'b00, 2'b00, 4'd0, 4'd0, 4'd2},  // R2 prio src3=5
    {1'b1, 6'h10, 8'h0F,  8'h00, 2'b00, 2'b00, 4'd0, 4'd0, 4'd2},  // R2 en t0
    {1'b1, 6'h11, 8'h09,  8'h00, 2'b00, 2'b00, 4'd0, 4'd0, 4'd2},  // R2 en t1
    {1'b1, 6'h21, 8'd2,   8'h00, 2'b00, 2'b00, 4'd0, 4'd0, 4'd2},  // R2 thr t1=2
    {1'b0, 6'h00, 8'd0,   8'h08, 2'b00, 2'b00, 4'd0, 4'd0, 4'd3},  // R3 set src4
    {1'b0, 6'h00, 8'd0,   8'h00, 2'b01, 2'b00, 4'd0, 4'd0, 4'd5},  // R5 R8 prio0 source
    {1'b0, 6'h00, 8'd0,   8'h01, 2'b00, 2'b00, 4'd0, 4'd0, 4'd3},  // R3 set src1
    {1'b0, 6'h00, 8'd0,   8'h00, 2'b00, 2'b11, 4'd0, 4'd0, 4'd4},  // R4 both raised
    {1'b0, 6'h00, 8'd0,   8'h06, 2'b00, 2'b11, 4'd0, 4'd0, 4'd3},  // R3 set src2,3
    {1'b0, 6'h00, 8'd0,   8'h00, 2'b01, 2'b11, 4'd0, 4'd2, 4'd6},  // R6 tie -> src2
    {1'b0, 6'h00, 8'd0,   8'h00, 2'b11, 2'b11, 4'd1, 4'd3, 4'd7},  // R7 both claim
    {1'b0, 6'h00, 8'd0,   8'h00, 2'b00, 2'b00, 4'd0, 4'd0, 4'd7},  // R7 cleared
    {1'b0, 6'h00, 8'd0,   8'h01, 2'b00, 2'b00, 4'd0, 4'd0, 4'd3},  // R3 set src1
    {1'b0, 6'h00, 8'd0,   8'h00, 2'b11, 2'b11, 4'd0, 4'd1, 4'd9},  // R9 shared claim
    {1'b0, 6'h00, 8'd0,   8'h00, 2'b00, 2'b00, 4'd0, 4'd0, 4'd9},  // R9 cleared once
    {1'b0, 6'h00, 8'd0,   8'h01, 2'b00, 2'b00, 4'd0, 4'd0, 4'd3},  // R3 set src1
    {1'b0, 6'h00, 8'd0,   8'h01, 2'b01, 2'b11, 4'd0, 4'd1, 4'd10}, // R10 claim+set
    {1'b0, 6'h00, 8'd0,   8'h01, 2'b00, 2'b00, 4'd0, 4'd0, 4'd10}, // R10 set dropped
    {1'b0, 6'h00, 8'd0,   8'h00, 2'b00, 2'b11, 4'd0, 4'd0, 4'd10}, // R10 held set taken
    {1'b1, 6'h21, 8'd3,   8'h00, 2'b00, 2'b11, 4'd0, 4'd0, 4'd11}, // R11 thr t1=3
    {1'b0, 6'h00, 8'd0,   8'h00, 2'b00, 2'b01, 4'd0, 4'd0, 4'd11}, // R11 t1 masked only
    {1'b1, 6'h20, 8'd7,   8'h00, 2'b00, 2'b01, 4'd0, 4'd0, 4'd4},  // R4 thr t0=7
    {1'b0, 6'h00, 8'd0,   8'h00, 2'b00, 2'b00, 4'd0, 4'd0, 4'd4}   // R4 none above 7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_idle();
    reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0; gw_set = '0; claim_req = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    drive_idle();
    claim_req = 2'b11;
    repeat (2) @(negedge clk);
    #2;
    check("R1 eip in reset", 32'(eip), 0);
    check("R1 claim in reset", 32'(claim_id), 0);
    @(negedge clk);
    rst_n = 1'b1;
    drive_idle();

    for (int i = 0; i < 25; i++) begin
      logic [VW-1:0] v;
      string tag;
      v = VEC[i];
      @(negedge clk);
      {reg_wr_en, reg_addr, reg_wdata, gw_set, claim_req} = v[VW-1:14];
      #2;
      tag = $sformatf("R%0d vec%0d", v[3:0], i);
      check({tag, " eip"}, 32'(eip), 32'(v[13:12]));
      check({tag, " claim"}, 32'(claim_id), 32'(v[11:4]));
    end

    // R2 read-back and ignored indices
    @(negedge clk); drive_idle(); reg_addr = 6'h02; #2;
    check("R2 read prio src2", 32'(reg_rdata), 5);
    reg_addr = 6'h11; #1;
    check("R2 read en t1", 32'(reg_rdata), 32'h09);
    reg_addr = 6'h20; #1;
    check("R2 read thr t0", 32'(reg_rdata), 7);
    reg_addr = 6'h12; #1;
    check("R2 read unused target", 32'(reg_rdata), 0);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = 6'h00; reg_wdata = 8'd6;
    @(negedge clk); drive_idle(); reg_addr = 6'h00; #2;
    check("R2 source id 0 not stored", 32'(reg_rdata), 0);

    // R1: reset mid-run with sources pending
    @(negedge clk); rst_n = 1'b0; claim_req = 2'b11; #2;
    check("R1 eip after reset", 32'(eip), 0);
    check("R1 claim after reset", 32'(claim_id), 0);
    @(negedge clk); rst_n = 1'b1; drive_idle(); reg_addr = 6'h02; #2;
    check("R1 prio cleared", 32'(reg_rdata), 0);
    reg_addr = 6'h10; #1;
    check("R1 enable cleared", 32'(reg_rdata), 0);
    // enable and prioritize src1 again: pending must have been cleared by reset
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = 6'h10; reg_wdata = 8'hFF;
    @(negedge clk); reg_addr = 6'h01; reg_wdata = 8'd7;
    @(negedge clk); drive_idle(); claim_req = 2'b01; #2;
    check("R1 pending cleared", 32'(eip), 0);
    check("R1 R8 empty claim", 32'(claim_id), 0);

    finish_run();
  end
endmodule